// File: doc/BRIEF.md
# Priority interrupt controller

This block gathers level-sensitive interrupt requests from a set of devices and presents one interrupt line to the CPU, together with the identifier of the device that won. Every source has a programmable 3-bit level that software can change at any time. Among the sources that pass the gating, the highest level wins, and equal levels go to the lower source index. Each source has its own mask bit, and one global enable bit gates every maskable source at once.

A separate non-maskable input carries serious-error alerts, such as an early warning of power loss. It is latched into a sticky pending flag. It ignores the enable and the mask bits, and it takes over the output even while a maskable interrupt is already being presented. It is reported with the reserved identifier whose bits are all ones.

Once the interrupt line is raised, the identifier stays frozen until the CPU pulses the acknowledge input. Only a non-maskable event can change it before then. After an acknowledge the line drops for one cycle, and the winner is then chosen again from the current requests.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `intr`, `dev_id` and `nmi_pending` are 0, the global enable is 0, every mask bit is 1 (blocked) and every level is 0. Whenever `intr` is 0, `dev_id` is 0.
- R2: While idle, `intr` rises at the first clock edge at which an eligible request is present. `dev_id` then carries the index of the eligible source with the highest level. A request is eligible when its `req` bit is 1, the global enable is 1 and its mask bit is 0.
- R3: When eligible sources share the highest level, the source with the lower index wins.
- R4: Bit i of `mask_wdata`, written when `mask_we` is 1, is the mask bit of source i. A value of 1 keeps that source from being selected.
- R5: The global enable bit is loaded from `en_wdata` when `en_we` is 1. While it is 0, no maskable source raises `intr`.
- R6: When `lvl_we` is 1, `lvl_wdata` becomes the level of source `lvl_idx`, and the new level takes part in selection from the next edge on. A `lvl_idx` of `NSRC` or above changes no level.
- R7: A 1 on `nmi` raises `intr` at the next edge with `dev_id` all ones. The global enable and the mask bits have no effect on this.
- R8: While `intr` is 1 and `ack` is 0, `dev_id` holds its value even when a higher request appears. The only exception is a non-maskable event.
- R9: An edge with `intr` and `ack` both at 1 clears `intr` and `dev_id`. The winner is chosen again at the following edge.
- R10: A non-maskable event that arrives while a maskable identifier is held replaces it with all ones at the next edge, without waiting for `ack`.
- R11: `nmi_pending` becomes 1 at the edge after `nmi` is seen high. It stays 1 until an `ack` of the all-ones identifier arrives while `nmi` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NSRC | Level request lines, one per source |
| nmi | input | 1 | Non-maskable request |
| en_we | input | 1 | Write strobe for the global enable |
| en_wdata | input | 1 | New global enable value |
| mask_we | input | 1 | Write strobe for the mask vector |
| mask_wdata | input | NSRC | New mask vector, 1 blocks a source |
| lvl_we | input | 1 | Write strobe for one source level |
| lvl_idx | input | IDW | Source whose level is written |
| lvl_wdata | input | LVLW | New level |
| ack | input | 1 | CPU acknowledge pulse |
| intr | output | 1 | Interrupt request to the CPU |
| dev_id | output | IDW | Winning source, all ones for the non-maskable input |
| nmi_pending | output | 1 | Non-maskable event latched and not yet acknowledged |

## Verification
A corrupted level or mask register shows up as a wrong `dev_id` at the first selection that involves that source. This is one edge after the request is applied, so each table vector pairs sources at known levels, including tied levels, to expose it. A hold register that fails to freeze is caught at once, because a higher request is raised under a held identifier. A non-maskable flag that clears too early or too late shows up on `nmi_pending` and `dev_id` within one or two edges of an acknowledge.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 8,
  parameter int LVLW = 3,
  parameter int IDW  = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic            nmi,
  input  logic            en_we,
  input  logic            en_wdata,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic            lvl_we,
  input  logic [IDW-1:0]  lvl_idx,
  input  logic [LVLW-1:0] lvl_wdata,
  input  logic            ack,
  output logic            intr,
  output logic [IDW-1:0]  dev_id,
  output logic            nmi_pending
);

  localparam logic [IDW-1:0] NMI_ID = '1;

  logic            en_q;
  logic [NSRC-1:0] mask_q;
  logic [LVLW-1:0] lvl_q [NSRC];
  logic            nmi_q;
  logic            intr_q;
  logic [IDW-1:0]  id_q;

  logic [NSRC-1:0] elig;
  logic            hit;
  logic [LVLW-1:0] best_l;
  logic [IDW-1:0]  best_i;
  logic            nmi_act;
  logic            nmi_taken;
  logic            cand_v;
  logic [IDW-1:0]  cand_id;

  assign elig      = req & ~mask_q & {NSRC{en_q}};
  assign nmi_act   = nmi | nmi_q;
  assign nmi_taken = intr_q & ack & (id_q == NMI_ID);

  always_comb begin
    hit    = 1'b0;
    best_l = '0;
    best_i = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!hit || lvl_q[i] > best_l)) begin
        hit    = 1'b1;
        best_l = lvl_q[i];
        best_i = IDW'(i);
      end
    end
  end

  assign cand_v  = nmi_act | hit;
  assign cand_id = nmi_act ? NMI_ID : best_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '1;
      nmi_q  <= 1'b0;
      intr_q <= 1'b0;
      id_q   <= '0;
    end else begin
      if (en_we)   en_q   <= en_wdata;
      if (mask_we) mask_q <= mask_wdata;
      nmi_q <= nmi | (nmi_q & ~nmi_taken);
      if (intr_q && ack) begin
        intr_q <= 1'b0;
        id_q   <= '0;
      end else if (!intr_q || (nmi_act && id_q != NMI_ID)) begin
        intr_q <= cand_v;
        id_q   <= cand_id;
      end
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rst_n)
        lvl_q[g] <= '0;
      else if (lvl_we && lvl_idx == IDW'(g))
        lvl_q[g] <= lvl_wdata;
    end
  end

  assign intr        = intr_q;
  assign dev_id      = id_q;
  assign nmi_pending = nmi_q;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int IDW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ack,
  input logic           nmi,
  input logic           intr,
  input logic [IDW-1:0] dev_id,
  input logic           nmi_pending,
  input logic           en_q
);

  localparam logic [IDW-1:0] ONES = '1;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !intr |-> dev_id == '0); // R1

  AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr) && dev_id != ONES |-> $past(en_q)); // R5

  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    intr && !ack && (nmi || nmi_pending) |=> intr && dev_id == ONES); // R10

  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    intr && !ack && !nmi && !nmi_pending |=> intr && $stable(dev_id)); // R8

  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    intr && ack |=> !intr); // R9

  AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pending && !(intr && ack && dev_id == ONES) |=> nmi_pending); // R11

  AST_NMI_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> nmi_pending); // R7

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .nmi(nmi), .intr(intr),
  .dev_id(dev_id), .nmi_pending(nmi_pending), .en_q(en_q)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int NSRC = 8;
  localparam int LVLW = 3;
  localparam int IDW  = 4;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] req = '0, mask_wdata = '0;
  logic nmi = 0, en_we = 0, en_wdata = 0, mask_we = 0, lvl_we = 0, ack = 0;
  logic [IDW-1:0] lvl_idx = '0;
  logic [LVLW-1:0] lvl_wdata = '0;
  logic intr, nmi_pending;
  logic [IDW-1:0] dev_id;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.NSRC(NSRC), .LVLW(LVLW)) i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .nmi(nmi),
    .en_we(en_we), .en_wdata(en_wdata), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .lvl_we(lvl_we), .lvl_idx(lvl_idx), .lvl_wdata(lvl_wdata), .ack(ack),
    .intr(intr), .dev_id(dev_id), .nmi_pending(nmi_pending)
  );

  // {req, en, mask, exp_intr, exp_id}; levels: s0=1 s1=3 s2=5 s3=5 s4=7 s5=2 s6=7 s7=0
  localparam logic [21:0] VEC [10] = '{
    {8'h01, 1'b1, 8'h00, 1'b1, 4'h0},  // R2
    {8'h03, 1'b1, 8'h00, 1'b1, 4'h1},  // R2
    {8'h0C, 1'b1, 8'h00, 1'b1, 4'h2},  // R3
    {8'h50, 1'b1, 8'h00, 1'b1, 4'h4},  // R3
    {8'h5F, 1'b1, 8'h10, 1'b1, 4'h6},  // R4
    {8'hFF, 1'b0, 8'h00, 1'b0, 4'h0},  // R5
    {8'h80, 1'b1, 8'h00, 1'b1, 4'h7},  // R2
    {8'hA4, 1'b1, 8'h04, 1'b1, 4'h5},  // R4
    {8'h00, 1'b1, 8'h00, 1'b0, 4'h0},  // R2
    {8'hFF, 1'b1, 8'hFF, 1'b0, 4'h0}   // R4
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_lvl(input logic [IDW-1:0] idx, input logic [LVLW-1:0] v);
    @(negedge clk); lvl_we = 1; lvl_idx = idx; lvl_wdata = v;
    @(negedge clk); lvl_we = 0;
  endtask

  task automatic do_ack;
    ack = 1; @(negedge clk); ack = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 intr", intr, 0);
    check("R1 dev_id", dev_id, 0);
    check("R1 nmi_pending", nmi_pending, 0);
    req = 8'hFF;
    @(negedge clk);
    check("R1 default gating", intr, 0);
    req = 0;
    set_lvl(0, 1); set_lvl(1, 3); set_lvl(2, 5); set_lvl(3, 5);
    set_lvl(4, 7); set_lvl(5, 2); set_lvl(6, 7); set_lvl(7, 0);

    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      en_we = 1; en_wdata = VEC[k][13]; mask_we = 1; mask_wdata = VEC[k][12:5]; req = 0;
      @(negedge clk);
      en_we = 0; mask_we = 0; req = VEC[k][21:14];
      @(negedge clk);
      check($sformatf("R2-R5 vec%0d intr", k), intr, VEC[k][4]);
      check($sformatf("R2-R5 vec%0d dev_id", k), dev_id, VEC[k][3:0]);
      req = 0;
      do_ack;
      @(negedge clk);
    end

    // enable on, no masks
    @(negedge clk); en_we = 1; en_wdata = 1; mask_we = 1; mask_wdata = 0;
    @(negedge clk); en_we = 0; mask_we = 0;

    // R6 out-of-range index ignored, then real remap
    set_lvl(4'd8, 7);
    req = 8'h03; @(negedge clk);
    check("R6 out-of-range index", dev_id, 1);
    req = 0; do_ack; @(negedge clk);
    set_lvl(0, 7);
    req = 8'h03; @(negedge clk);
    check("R6 remap", dev_id, 0);
    req = 0; do_ack; @(negedge clk);
    set_lvl(0, 1);

    // R8 hold while a higher request arrives
    req = 8'h01; @(negedge clk);
    check("R8 first winner", dev_id, 0);
    req = 8'h11; repeat (3) @(negedge clk);
    check("R8 held intr", intr, 1);
    check("R8 held dev_id", dev_id, 0);

    // R9 ack drops, then reselects
    ack = 1; @(negedge clk); ack = 0;
    check("R9 intr dropped", intr, 0);
    check("R9 dev_id cleared", dev_id, 0);
    @(negedge clk);
    check("R9 reselect", dev_id, 4);

    // R10 / R11 NMI preempts held id
    nmi = 1; @(negedge clk); nmi = 0;
    check("R10 preempt id", dev_id, 4'hF);
    check("R11 pending set", nmi_pending, 1);
    repeat (3) @(negedge clk);
    check("R11 pending sticky", nmi_pending, 1);
    check("R10 id stays nmi", dev_id, 4'hF);
    ack = 1; @(negedge clk); ack = 0;
    check("R11 pending cleared", nmi_pending, 0);
    check("R9 intr dropped after nmi", intr, 0);
    @(negedge clk);
    check("R9 maskable after nmi", dev_id, 4);
    req = 0; do_ack; @(negedge clk);

    // R7 NMI ignores enable and masks
    en_we = 1; en_wdata = 0; mask_we = 1; mask_wdata = 8'hFF;
    @(negedge clk); en_we = 0; mask_we = 0;
    nmi = 1; @(negedge clk);
    check("R7 nmi intr", intr, 1);
    check("R7 nmi id", dev_id, 4'hF);
    ack = 1; @(negedge clk); ack = 0;
    check("R11 pending kept while nmi high", nmi_pending, 1);
    nmi = 0;
    @(negedge clk);
    check("R7 nmi reraised", dev_id, 4'hF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule